// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters for a processor. A mode byte written by software sets the character length, the parity rule and the oversampling ratio. The line is resynchronised and sampled on an internal tick. A falling edge starts a frame, and that start is confirmed at the middle of the start bit. Each later bit is taken at the middle of its period. Parity and the first stop bit are checked on the way.

A finished character goes into a data register and raises a ready flag. Reading the data register through a strobe clears that flag. Parity, overrun and framing faults are kept in sticky flags until a command write clears them. Another command bit returns the receiver to an idle, cleared state. A command bit also gates reception as a whole. One modem-status input is passed through to the status byte. The stop-length field of the mode byte is stored but does not affect reception, because only the first stop bit is checked.

Top module: `serial_rx`

## Requirements
- R1: After reset, all status bits and `rx_data` are zero, the receiver is disabled, and the mode byte is 0x4E.
- R2: Mode bits [3:2] select the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. The character is right-aligned in `rx_data`, and its unused upper bits read zero.
- R3: Mode bits [5:4] select parity: 01 is odd, 11 is even, and 00 or 10 means there is no parity bit in the frame. A parity mismatch sets status bit 1.
- R4: Mode bits [1:0] equal to 11 give 64 ticks per bit. Any other value gives 16 ticks per bit. One tick lasts TICK_DIV clock cycles.
- R5: A low pulse shorter than half a bit, which is gone at the half-bit sample point, produces no character.
- R6: Command bit 2 enables the receiver. While it is clear, frames on the line are ignored and the ready flag stays clear.
- R7: Status bit 0 (ready) is set when a character completes. A pulse on `data_rd` clears it.
- R8: A character that completes while ready is still set raises status bit 2 (overrun) and replaces the data register.
- R9: A low stop bit sets status bit 3 (framing). The character is still delivered.
- R10: The error flags stay set until a command write with bit 4 set clears all three at once. Ready is left as it was.
- R11: A command write with bit 6 set returns the receiver to idle. It clears status bits 0 to 3 and the data register, and it clears the enable.
- R12: Status bit 7 follows `modem_in` after two clock cycles of synchronisation. Status bits 4 to 6 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| wdata | input | 8 | Write data for the mode and command registers |
| mode_wr | input | 1 | Writes `wdata` into the mode register |
| cmd_wr | input | 1 | Applies `wdata` as a command |
| data_rd | input | 1 | Read strobe for the data register |
| modem_in | input | 1 | Modem-status input passed to status bit 7 |
| rx_data | output | 8 | Last received character, right-aligned |
| status | output | 8 | Status flags: bit 0 ready, 1 parity, 2 overrun, 3 framing, 7 modem |

## Verification
The hardest case to reach from the ports is overrun. It needs two whole frames to finish while software leaves the data register unread. The bench monitor has an auto-read switch for this. The bench turns it off, sends two frames back to back, and then turns it on with one expected entry that carries the overrun flag and the second character. A false start is produced by a low glitch shorter than half a bit. The 64x ratio is covered by a separate frame that uses the longer bit time.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  localparam int ST_READY  = 0;
  localparam int ST_PERR   = 1;
  localparam int ST_OVR    = 2;
  localparam int ST_FERR   = 3;
  localparam int ST_MODEM  = 7;

  localparam logic [7:0] MODE_RESET = 8'h4E;

  function automatic logic [3:0] char_bits(input logic [1:0] len_f);
    return 4'd5 + {2'b00, len_f};
  endfunction

  function automatic logic [6:0] ticks_per_bit(input logic [1:0] pre_f);
    return (pre_f == 2'b11) ? 7'd64 : 7'd16;
  endfunction

endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          enable,
  input  logic          tick,
  input  logic          line_s,
  input  logic [7:0]    mode,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          par_err,
  output logic          frm_err
);
  rx_state_t       state;
  logic [6:0]      cnt;
  logic [3:0]      bidx;
  logic [DW-1:0]   shreg;
  logic            par_acc;
  logic            perr_q;

  logic [3:0] nbits;
  logic [6:0] spb;
  logic [6:0] half;
  logic       par_on;
  logic       par_odd;
  logic       bit_end;

  always_comb begin
    nbits   = char_bits(mode[3:2]);
    spb     = ticks_per_bit(mode[1:0]);
    half    = (spb >> 1) - 7'd1;
    par_on  = mode[4];
    par_odd = ~mode[5];
    bit_end = (cnt == spb - 7'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
      end else if (tick) begin
        case (state)
          ST_IDLE: if (!line_s) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: if (cnt == half) begin
            if (!line_s) begin
              state   <= ST_DATA;
              cnt     <= '0;
              bidx    <= '0;
              par_acc <= 1'b0;
              perr_q  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 7'd1;
          end
          ST_DATA: if (bit_end) begin
            cnt     <= '0;
            shreg   <= {line_s, shreg[DW-1:1]};
            par_acc <= par_acc ^ line_s;
            if (bidx == nbits - 4'd1) state <= par_on ? ST_PAR : ST_STOP;
            else bidx <= bidx + 4'd1;
          end else begin
            cnt <= cnt + 7'd1;
          end
          ST_PAR: if (bit_end) begin
            cnt    <= '0;
            perr_q <= par_odd ? ~(par_acc ^ line_s) : (par_acc ^ line_s);
            state  <= ST_STOP;
          end else begin
            cnt <= cnt + 7'd1;
          end
          ST_STOP: if (bit_end) begin
            cnt     <= '0;
            done    <= 1'b1;
            data    <= shreg >> (4'd8 - nbits);
            par_err <= par_on & perr_q;
            frm_err <= ~line_s;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt + 7'd1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state == ST_IDLE && !done));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ((data >> nbits) == '0));

  assert_no_parity_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !par_on) |-> !par_err);
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          done,
  input  logic [DW-1:0] data_in,
  input  logic          perr_in,
  input  logic          ferr_in,
  input  logic          rd,
  input  logic          clr_err,
  output logic [DW-1:0] data_q,
  output logic          ready,
  output logic          perr,
  output logic          ovr,
  output logic          ferr
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      data_q <= '0;
      ready  <= 1'b0;
      perr   <= 1'b0;
      ovr    <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      if (clr_err) begin
        perr <= 1'b0;
        ovr  <= 1'b0;
        ferr <= 1'b0;
      end
      if (done) begin
        data_q <= data_in;
        ready  <= 1'b1;
        if (perr_in) perr <= 1'b1;
        if (ferr_in) ferr <= 1'b1;
        if (ready && !rd) ovr <= 1'b1;
      end else if (rd) begin
        ready <= 1'b0;
      end
    end
  end

  assert_ready_set_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !soft_rst) |=> ready);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (rd && !done) |=> !ready);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    (done && ready && !rd && !soft_rst) |=> ovr);

  assert_clear_errs_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !done) |=> !(perr || ovr || ferr));

  assert_ready_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !done && !rd && !soft_rst) |=> (ready == $past(ready)));
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int TICK_DIV = 2,
  parameter int SYNC_FF  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line,
  input  logic [7:0] wdata,
  input  logic       mode_wr,
  input  logic       cmd_wr,
  input  logic       data_rd,
  input  logic       modem_in,
  output logic [7:0] rx_data,
  output logic [7:0] status
);
  localparam int DW = 8;

  logic [7:0]         mode_q;
  logic               enable_q;
  logic [SYNC_FF-1:0] line_sync;
  logic [SYNC_FF-1:0] modem_sync;
  logic               soft_rst;
  logic               clr_err;
  logic               tick;
  logic               done;
  logic [DW-1:0]      fr_data;
  logic               fr_perr;
  logic               fr_ferr;
  logic               ready, perr, ovr, ferr;

  assign soft_rst = cmd_wr & wdata[6];
  assign clr_err  = cmd_wr & wdata[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_RESET;
      enable_q   <= 1'b0;
      line_sync  <= '1;
      modem_sync <= '0;
    end else begin
      line_sync  <= {line_sync[SYNC_FF-2:0], rx_line};
      modem_sync <= {modem_sync[SYNC_FF-2:0], modem_in};
      if (mode_wr) mode_q <= wdata;
      if (soft_rst) enable_q <= 1'b0;
      else if (cmd_wr) enable_q <= wdata[2];
    end
  end

  rx_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  rx_frame_fsm #(.DW(DW)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .abort  (soft_rst),
    .enable (enable_q),
    .tick   (tick),
    .line_s (line_sync[SYNC_FF-1]),
    .mode   (mode_q),
    .done   (done),
    .data   (fr_data),
    .par_err(fr_perr),
    .frm_err(fr_ferr)
  );

  rx_status_regs #(.DW(DW)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .soft_rst(soft_rst),
    .done    (done),
    .data_in (fr_data),
    .perr_in (fr_perr),
    .ferr_in (fr_ferr),
    .rd      (data_rd),
    .clr_err (clr_err),
    .data_q  (rx_data),
    .ready   (ready),
    .perr    (perr),
    .ovr     (ovr),
    .ferr    (ferr)
  );

  always_comb begin
    status           = '0;
    status[ST_READY] = ready;
    status[ST_PERR]  = perr;
    status[ST_OVR]   = ovr;
    status[ST_FERR]  = ferr;
    status[ST_MODEM] = modem_sync[SYNC_FF-1];
  end

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (status[3:0] == 4'h0 && rx_data == 8'h00));

  assert_disable_after_soft_R11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !enable_q);
endmodule

// File: tb/serial_rx_tb_top.sv
module serial_rx_tb_top;
  localparam int TICK_DIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic [7:0] wdata = '0;
  logic       mode_wr = 1'b0;
  logic       cmd_wr = 1'b0;
  logic       data_rd = 1'b0;
  logic       modem_in = 1'b0;
  logic [7:0] rx_data;
  logic [7:0] status;

  int errors = 0;
  int checks = 0;
  bit auto_rd = 1'b1;
  bit finished = 1'b0;

  // expected item: {data[7:0], parity, overrun, framing}
  logic [10:0] exp_q[$];

  always #4 clk = ~clk;

  serial_rx #(.TICK_DIV(TICK_DIV)) dut_i (
    .clk(clk), .rst(rst), .rx_line(rx_line), .wdata(wdata),
    .mode_wr(mode_wr), .cmd_wr(cmd_wr), .data_rd(data_rd),
    .modem_in(modem_in), .rx_data(rx_data), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); wdata = v; mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic wr_cmd(input logic [7:0] v);
    @(negedge clk); wdata = v; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pmode: 0 none, 1 odd, 2 even
  task automatic send_frame(input logic [7:0] d, input int nb, input int pmode,
                            input bit bad_par, input bit stop_v, input int spb,
                            input bit push, input logic [2:0] exp_flags);
    int bt;
    logic [7:0] mask;
    logic ones, pbit;
    bt = spb * TICK_DIV;
    mask = 8'hFF >> (8 - nb);
    ones = ^(d & mask);
    pbit = (pmode == 1) ? ~ones : ones;
    if (bad_par) pbit = ~pbit;
    if (push) exp_q.push_back({d & mask, exp_flags});
    @(negedge clk);
    rx_line = 1'b0; hold(bt);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i]; hold(bt);
    end
    if (pmode != 0) begin
      rx_line = pbit; hold(bt);
    end
    rx_line = stop_v; hold(bt);
    rx_line = 1'b1; hold(bt);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && auto_rd && status[0]) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected character", rx_data, 0);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e[10:3], "R2 data", rx_data, e[10:3]);
          chk(status[1] == e[2], "R3 parity flag", status[1], e[2]);
          chk(status[2] == e[1], "R8 overrun flag", status[2], e[1]);
          chk(status[3] == e[0], "R9 framing flag", status[3], e[0]);
        end
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        @(negedge clk);
        chk(status[0] == 1'b0, "R7 read clears ready", status[0], 0);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    hold(4);
    rst = 1'b0;
    hold(2);
    chk(status == 8'h00, "R1 status after reset", status, 0);
    chk(rx_data == 8'h00, "R1 data after reset", rx_data, 0);

    // R6: disabled receiver ignores a frame
    send_frame(8'h5A, 8, 0, 0, 1, 16, 0, 3'b000);
    chk(status[0] == 1'b0, "R6 ignored while disabled", status[0], 0);

    wr_cmd(8'h04);
    // R2/R7: 8N1 at 16x (reset mode 0x4E)
    send_frame(8'hA5, 8, 0, 0, 1, 16, 1, 3'b000);
    send_frame(8'h3C, 8, 0, 0, 1, 16, 1, 3'b000);

    // R2: 5-bit characters, upper bits zero
    wr_mode(8'h42);
    send_frame(8'hF3, 5, 0, 0, 1, 16, 1, 3'b000);

    // R3: 7-bit odd parity, good then bad, then sticky (R10)
    wr_mode(8'h5A);
    send_frame(8'h55, 7, 1, 0, 1, 16, 1, 3'b000);
    send_frame(8'h2B, 7, 1, 1, 1, 16, 1, 3'b100);
    send_frame(8'h11, 7, 1, 0, 1, 16, 1, 3'b100);
    chk(status[1] == 1'b1, "R10 parity flag sticky", status[1], 1);
    wr_cmd(8'h14);
    chk(status[1] == 1'b0, "R10 clear command", status[1], 0);

    // R3: 6-bit even parity
    wr_mode(8'h76);
    send_frame(8'h2D, 6, 2, 0, 1, 16, 1, 3'b000);
    send_frame(8'h0E, 6, 2, 1, 1, 16, 1, 3'b100);
    wr_cmd(8'h14);

    // R4: 64x prescaler
    wr_mode(8'h4F);
    send_frame(8'h81, 8, 0, 0, 1, 64, 1, 3'b000);

    // R9: framing error, character still delivered
    wr_mode(8'h4E);
    send_frame(8'h6E, 8, 0, 0, 0, 16, 1, 3'b001);
    wr_cmd(8'h14);
    chk(status[3] == 1'b0, "R10 framing cleared", status[3], 0);

    // R5: false start glitch
    @(negedge clk); rx_line = 1'b0; hold(4); rx_line = 1'b1;
    hold(16 * TICK_DIV * 12);
    chk(status[0] == 1'b0, "R5 false start ignored", status[0], 0);

    // R8: overrun with reads held off
    auto_rd = 1'b0;
    send_frame(8'h12, 8, 0, 0, 1, 16, 0, 3'b000);
    send_frame(8'h34, 8, 0, 0, 1, 16, 0, 3'b000);
    chk(status[2] == 1'b1, "R8 overrun set", status[2], 1);
    chk(rx_data == 8'h34, "R8 newer character kept", rx_data, 8'h34);
    exp_q.push_back({8'h34, 3'b010});
    auto_rd = 1'b1;
    hold(6);
    wr_cmd(8'h14);

    // R11: internal reset
    auto_rd = 1'b0;
    send_frame(8'h77, 8, 0, 0, 0, 16, 0, 3'b000);
    chk(status[0] && status[3], "R11 precondition", status, 8'h09);
    wr_cmd(8'h40);
    chk(status[3:0] == 4'h0, "R11 status cleared", status, 0);
    chk(rx_data == 8'h00, "R11 data cleared", rx_data, 0);
    send_frame(8'h99, 8, 0, 0, 1, 16, 0, 3'b000);
    chk(status[0] == 1'b0, "R11 enable cleared", status[0], 0);
    wr_cmd(8'h04);
    auto_rd = 1'b1;

    // R12: modem pass-through
    chk(status[7] == 1'b0, "R12 modem low", status[7], 0);
    @(negedge clk); modem_in = 1'b1;
    hold(3);
    chk(status[7] == 1'b1, "R12 modem high", status[7], 1);
    chk(status[6:4] == 3'b000, "R12 spare bits zero", status[6:4], 0);

    hold(20);
    chk(exp_q.size() == 0, "R7 all characters delivered", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule